// File: doc/BRIEF.md
# Paired-Page Event-State Controller

This block keeps two-bit pending/queued (P/Q) event-state buffers for a set of queue descriptors and lets software drive them through side-effecting loads and stores on a simple 64-bit register bus. Every descriptor owns two adjacent pages of address space. The lower (even) page reaches the descriptor's notification state. The upper (odd) page reaches its escalation state. The offset of an access within the page selects the operation: trigger, end-of-interrupt (EOI), query, set or inject.

Each accepted request is answered one clock later. Loads return data and stores do not. When a store leaves behind a notification that must travel on, the block raises a one-cycle forward strobe that names the descriptor and the page. Routing that notification further is the job of the logic downstream. Stores carry no meaningful payload, so the block has no write-data port.

The page size is a parameter and must be 4 KiB or 64 KiB. Any other value stops elaboration. The set of populated descriptors is fixed by a parameter mask.

Top module: `esb_pair_ctl`

## Requirements
- R1: The descriptor index is `reqAddr >> (PAGE_SHIFT+1)`. Address bit `PAGE_SHIFT` selects the page: 0 is notification and 1 is escalation. The two states of a descriptor change independently, and only address bits [11:0] form the operation offset.
- R2: Stores at offsets 0x000–0x3FF trigger. The transitions are 00→10 with notify, 10→11, 11→11, and 01→01 with no notify. Notify pulses `fwdValid`.
- R3: EOI maps 11→10 with notify and maps 00, 01 and 10 to 00 without notify. Loads at 0x000–0x7FF perform EOI and return the notify flag as the value. Stores at 0x400–0x7FF perform EOI and forward on notify.
- R4: Loads at 0x800–0xBFF return the current state and leave it unchanged.
- R5: Loads at 0xC00–0xFFF write the state to `offset[9:8]` and return the state held before the write.
- R6: Stores at 0x800–0xBFF on a notification page forward a notification and leave the state unchanged. On an escalation page the same stores do nothing and forward nothing.
- R7: An access to a descriptor that is out of range or absent from `DESC_VALID`, and any store at 0xC00–0xFFF, changes no state and forwards nothing. Such loads return all ones.
- R8: Only 8-byte accesses (`reqSize` = 3) are acted on. Other sizes change nothing, and loads of other sizes return all ones.
- R9: Data is big-endian. A two-bit load value appears in `rspData[57:56]` with every other bit 0. `rspValid` rises, and `fwdValid`/`fwdDesc`/`fwdEsc` take their values, on the clock edge after the one that accepts the request.
- R10: After reset every state is 00, `rspValid`, `fwdValid` and `rspData` are 0.
- R11: A load never pulses `fwdValid`, even when its EOI reports a notification.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request accepted on this edge |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqAddr | input | ADDR_W | Byte address of the access |
| reqSize | input | 2 | log2 of the access size in bytes |
| rspValid | output | 1 | Response for the request of the previous cycle |
| rspData | output | 64 | Big-endian load data, 0 for stores |
| fwdValid | output | 1 | Notification to forward |
| fwdDesc | output | IDX_W | Descriptor of the forwarded notification |
| fwdEsc | output | 1 | Forwarded notification came from the escalation page |

## Verification
The bench steps one descriptor through every trigger and EOI transition. It covers the stuck 01 state, where a trigger that wrongly fires would forward a spurious notification, and the 11 state, where an EOI that fails to re-arm would lose the queued event. It then checks that the escalation page keeps separate state. An inject that is not refused there would forward, and a page bit that is decoded wrongly would leak state between the pages. It also probes an absent descriptor, an out-of-range descriptor, the undefined store range and undersized accesses: a design that let these through would alter state that a later query reveals, or would return something other than all ones. A mid-run reset must bring every state back to 00.

// File: rtl/esb_pair_pkg.sv
`timescale 1ns/1ps
package esb_pair_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_LD_EOI,
    OP_GET,
    OP_SET,
    OP_TRIG,
    OP_ST_EOI,
    OP_INJECT
  } esbOp_e;

  // Strobes from the decoder to the state datapath
  typedef struct packed {
    logic       go;
    logic       isLoad;
    logic       escPage;
    esbOp_e     op;
    logic [1:0] setVal;
  } esbStrobe_t;

  // Returns {notify, nextState}
  function automatic logic [2:0] pqTrigger(input logic [1:0] pq);
    case (pq)
      2'b00:   pqTrigger = {1'b1, 2'b10};
      2'b01:   pqTrigger = {1'b0, 2'b01};
      default: pqTrigger = {1'b0, 2'b11};
    endcase
  endfunction

  function automatic logic [2:0] pqEoi(input logic [1:0] pq);
    if (pq == 2'b11) pqEoi = {1'b1, 2'b10};
    else             pqEoi = {1'b0, 2'b00};
  endfunction

endpackage

// File: rtl/esb_pair_decode.sv
`timescale 1ns/1ps
module esb_pair_decode
  import esb_pair_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int PAGE_SHIFT = 12,
  parameter int NUM_DESC   = 8,
  parameter logic [NUM_DESC-1:0] DESC_VALID = '1,
  parameter int IDX_W      = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  output esbStrobe_t        strb,
  output logic [IDX_W-1:0]  descIdx
);
  localparam int FULL_W = ADDR_W - PAGE_SHIFT - 1;
  localparam logic [FULL_W-1:0] NUM_L = FULL_W'(NUM_DESC);

  logic [FULL_W-1:0] fullIdx;
  logic [3:0]        offHi;
  logic              escSel;
  logic              descOk;
  logic              sizeOk;
  logic              unusedAddrLow;
  esbOp_e            opSel;

  assign fullIdx       = reqAddr[ADDR_W-1:PAGE_SHIFT+1];
  assign offHi         = reqAddr[11:8];
  assign escSel        = reqAddr[PAGE_SHIFT];
  assign unusedAddrLow = ^reqAddr[PAGE_SHIFT-1:8] ^ ^reqAddr[7:0];
  assign descIdx       = fullIdx[IDX_W-1:0];
  assign descOk        = (fullIdx < NUM_L) && DESC_VALID[descIdx];
  assign sizeOk        = (reqSize == 2'd3);

  always_comb begin
    opSel = OP_NONE;
    if (sizeOk && descOk) begin
      if (!reqWrite) begin
        if (!offHi[3])      opSel = OP_LD_EOI;
        else if (!offHi[2]) opSel = OP_GET;
        else                opSel = OP_SET;
      end else begin
        case (offHi[3:2])
          2'b00:   opSel = OP_TRIG;
          2'b01:   opSel = OP_ST_EOI;
          2'b10:   opSel = escSel ? OP_NONE : OP_INJECT;
          default: opSel = OP_NONE;
        endcase
      end
    end
  end

  always_comb begin
    strb.go      = reqValid;
    strb.isLoad  = !reqWrite;
    strb.escPage = escSel;
    strb.op      = opSel;
    strb.setVal  = offHi[1:0];
  end

  // R6: inject is never issued for an escalation page
  a_r6_esc_inject_refused: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && reqAddr[PAGE_SHIFT] && reqAddr[11:10] == 2'b10)
      |-> strb.op != OP_INJECT);

  // R8: accesses of the wrong size decode to no operation
  a_r8_size_refused: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSize != 2'd3) |-> strb.op == OP_NONE);

endmodule

// File: rtl/esb_pair_state.sv
`timescale 1ns/1ps
module esb_pair_state
  import esb_pair_pkg::*;
#(
  parameter int NUM_DESC = 8,
  parameter int IDX_W    = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  esbStrobe_t       strb,
  input  logic [IDX_W-1:0] descIdx,
  output logic             rspValid,
  output logic [63:0]      rspData,
  output logic             fwdValid,
  output logic [IDX_W-1:0] fwdDesc,
  output logic             fwdEsc
);
  logic [1:0] pqNtf [NUM_DESC];
  logic [1:0] pqEsc [NUM_DESC];
  logic [1:0] curPq;
  logic [1:0] nextPq;
  logic [1:0] retVal;
  logic       ntf;
  logic       wrEn;

  assign curPq = strb.escPage ? pqEsc[descIdx] : pqNtf[descIdx];

  always_comb begin
    nextPq = curPq;
    retVal = curPq;
    ntf    = 1'b0;
    case (strb.op)
      OP_LD_EOI: begin
        {ntf, nextPq} = pqEoi(curPq);
        retVal        = {1'b0, ntf};
      end
      OP_SET:    nextPq = strb.setVal;
      OP_TRIG:   {ntf, nextPq} = pqTrigger(curPq);
      OP_ST_EOI: {ntf, nextPq} = pqEoi(curPq);
      OP_INJECT: ntf = 1'b1;
      default:   ;
    endcase
  end

  // Only a changed value is written back
  assign wrEn = strb.go && (nextPq != curPq);

  for (genvar i = 0; i < NUM_DESC; i++) begin : g_entry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pqNtf[i] <= 2'b00;
        pqEsc[i] <= 2'b00;
      end else if (wrEn && descIdx == IDX_W'(i)) begin
        if (strb.escPage) pqEsc[i] <= nextPq;
        else              pqNtf[i] <= nextPq;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
      fwdValid <= 1'b0;
      fwdDesc  <= '0;
      fwdEsc   <= 1'b0;
    end else begin
      rspValid <= strb.go;
      if (strb.go && strb.isLoad)
        rspData <= (strb.op == OP_NONE) ? '1 : {6'b0, retVal, 56'b0};
      else
        rspData <= '0;
      fwdValid <= strb.go && !strb.isLoad && ntf;
      fwdDesc  <= descIdx;
      fwdEsc   <= strb.escPage;
    end
  end

  // R9: every request is answered on the next edge
  a_r9_rsp_follows: assert property (@(posedge clk) disable iff (!rstN)
    strb.go |=> rspValid);

  // R11: loads never forward
  a_r11_load_no_fwd: assert property (@(posedge clk) disable iff (!rstN)
    (strb.go && strb.isLoad) |=> !fwdValid);

  // R2: trigger on state 01 is blocked
  a_r2_trig_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (strb.go && strb.op == OP_TRIG && curPq == 2'b01) |=> !fwdValid);

  // R3: store EOI on 11 forwards
  a_r3_eoi_pending: assert property (@(posedge clk) disable iff (!rstN)
    (strb.go && strb.op == OP_ST_EOI && curPq == 2'b11) |=> fwdValid);

  // R6: inject on a notification page forwards
  a_r6_inject_fwd: assert property (@(posedge clk) disable iff (!rstN)
    (strb.go && strb.op == OP_INJECT) |=> fwdValid);

endmodule

// File: rtl/esb_pair_ctl.sv
`timescale 1ns/1ps
module esb_pair_ctl
  import esb_pair_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int PAGE_SHIFT = 12,
  parameter int NUM_DESC   = 8,
  parameter logic [NUM_DESC-1:0] DESC_VALID = 8'b1011_1111,
  localparam int IDX_W     = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  output logic              rspValid,
  output logic [63:0]       rspData,
  output logic              fwdValid,
  output logic [IDX_W-1:0]  fwdDesc,
  output logic              fwdEsc
);
  if (PAGE_SHIFT != 12 && PAGE_SHIFT != 16) begin : g_bad_page
    $error("esb_pair_ctl: PAGE_SHIFT must be 12 or 16");
  end

  esbStrobe_t       strb;
  logic [IDX_W-1:0] descIdx;

  esb_pair_decode #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .NUM_DESC(NUM_DESC),
    .DESC_VALID(DESC_VALID), .IDX_W(IDX_W)
  ) u_decode (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSize(reqSize), .strb(strb), .descIdx(descIdx)
  );

  esb_pair_state #(.NUM_DESC(NUM_DESC), .IDX_W(IDX_W)) u_state (
    .clk(clk), .rstN(rstN), .strb(strb), .descIdx(descIdx),
    .rspValid(rspValid), .rspData(rspData), .fwdValid(fwdValid),
    .fwdDesc(fwdDesc), .fwdEsc(fwdEsc)
  );

endmodule

// File: tb/sim_esb_pair_ctl.sv
`timescale 1ns/1ps
module sim_esb_pair_ctl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [19:0] reqAddr = '0;
  logic [1:0]  reqSize = 2'd3;
  logic        rspValid;
  logic [63:0] rspData;
  logic        fwdValid;
  logic [2:0]  fwdDesc;
  logic        fwdEsc;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  esb_pair_ctl u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSize(reqSize), .rspValid(rspValid),
    .rspData(rspData), .fwdValid(fwdValid), .fwdDesc(fwdDesc), .fwdEsc(fwdEsc)
  );

  // {wr, desc[3:0], esc, off[11:0], size[1:0], expFwd, expRet[7:0]}
  localparam int NV = 33;
  localparam logic [28:0] VEC [NV] = '{
    {1'b0, 4'd0, 1'b0, 12'h800, 2'd3, 1'b0, 8'h00}, // R10 R4 reset state
    {1'b1, 4'd0, 1'b0, 12'h000, 2'd3, 1'b1, 8'h00}, // R2 00->10 notify
    {1'b1, 4'd0, 1'b0, 12'h3F8, 2'd3, 1'b0, 8'h00}, // R2 10->11
    {1'b1, 4'd0, 1'b0, 12'h000, 2'd3, 1'b0, 8'h00}, // R2 11->11
    {1'b0, 4'd0, 1'b0, 12'hBF8, 2'd3, 1'b0, 8'h03}, // R4 R9 read 11
    {1'b0, 4'd0, 1'b1, 12'h800, 2'd3, 1'b0, 8'h00}, // R1 escalation untouched
    {1'b1, 4'd0, 1'b0, 12'h400, 2'd3, 1'b1, 8'h00}, // R3 store EOI 11->10
    {1'b1, 4'd0, 1'b0, 12'h7F8, 2'd3, 1'b0, 8'h00}, // R3 store EOI 10->00
    {1'b0, 4'd0, 1'b0, 12'hD00, 2'd3, 1'b0, 8'h00}, // R5 set 01
    {1'b1, 4'd0, 1'b0, 12'h000, 2'd3, 1'b0, 8'h00}, // R2 01 blocked
    {1'b0, 4'd0, 1'b0, 12'h800, 2'd3, 1'b0, 8'h01}, // R2 still 01
    {1'b0, 4'd0, 1'b0, 12'h000, 2'd3, 1'b0, 8'h00}, // R3 load EOI 01->00
    {1'b0, 4'd0, 1'b0, 12'hF00, 2'd3, 1'b0, 8'h00}, // R5 set 11
    {1'b0, 4'd0, 1'b0, 12'h7F8, 2'd3, 1'b0, 8'h01}, // R3 R11 load EOI notify
    {1'b0, 4'd0, 1'b0, 12'h800, 2'd3, 1'b0, 8'h02}, // R3 now 10
    {1'b1, 4'd0, 1'b0, 12'h800, 2'd3, 1'b1, 8'h00}, // R6 inject
    {1'b0, 4'd0, 1'b0, 12'h800, 2'd3, 1'b0, 8'h02}, // R6 state kept
    {1'b1, 4'd0, 1'b1, 12'h800, 2'd3, 1'b0, 8'h00}, // R6 escalation inject refused
    {1'b0, 4'd0, 1'b1, 12'h800, 2'd3, 1'b0, 8'h00}, // R6 escalation still 00
    {1'b1, 4'd0, 1'b1, 12'h000, 2'd3, 1'b1, 8'h00}, // R1 escalation trigger
    {1'b0, 4'd0, 1'b1, 12'hC00, 2'd3, 1'b0, 8'h02}, // R5 set 00 returns prior
    {1'b0, 4'd0, 1'b1, 12'h800, 2'd3, 1'b0, 8'h00}, // R5 cleared
    {1'b1, 4'd6, 1'b0, 12'h000, 2'd3, 1'b0, 8'h00}, // R7 absent descriptor
    {1'b0, 4'd6, 1'b0, 12'h800, 2'd3, 1'b0, 8'hFF}, // R7 ones
    {1'b0, 4'd9, 1'b0, 12'h000, 2'd3, 1'b0, 8'hFF}, // R7 out of range
    {1'b1, 4'd1, 1'b0, 12'hC00, 2'd3, 1'b0, 8'h00}, // R7 undefined store
    {1'b0, 4'd1, 1'b0, 12'h800, 2'd3, 1'b0, 8'h00}, // R7 no change
    {1'b0, 4'd1, 1'b0, 12'h800, 2'd2, 1'b0, 8'hFF}, // R8 short load
    {1'b1, 4'd1, 1'b0, 12'h000, 2'd2, 1'b0, 8'h00}, // R8 short store
    {1'b0, 4'd1, 1'b0, 12'h800, 2'd3, 1'b0, 8'h00}, // R8 no change
    {1'b0, 4'd1, 1'b1, 12'hE00, 2'd3, 1'b0, 8'h00}, // R1 R5 set escalation 10
    {1'b0, 4'd1, 1'b0, 12'h800, 2'd3, 1'b0, 8'h00}, // R1 notification kept
    {1'b0, 4'd1, 1'b1, 12'h800, 2'd3, 1'b0, 8'h02}  // R1 escalation 10
  };

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [3:0] d, input logic e,
                        input logic [11:0] off, input logic [1:0] sz,
                        output logic rv, output logic [63:0] data,
                        output logic fv, output logic [2:0] fd, output logic fe);
    @(negedge clk);
    reqValid = 1'b1;
    reqWrite = wr;
    reqAddr  = {3'b0, d, e, off};
    reqSize  = sz;
    @(negedge clk);
    reqValid = 1'b0;
    rv = rspValid; data = rspData; fv = fwdValid; fd = fwdDesc; fe = fwdEsc;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      testsFailed++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic rv, fv, fe;
    logic [63:0] data, expData;
    logic [2:0] fd;
    repeat (3) @(negedge clk);
    // R10 reset outputs
    check(rspValid == 1'b0 && fwdValid == 1'b0 && rspData == 64'd0, "R10 reset outputs",
          {62'd0, rspValid, fwdValid}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic        vWr, vE, vFwd;
      logic [3:0]  vD;
      logic [11:0] vOff;
      logic [1:0]  vSz;
      logic [7:0]  vRet;
      {vWr, vD, vE, vOff, vSz, vFwd, vRet} = VEC[i];
      access(vWr, vD, vE, vOff, vSz, rv, data, fv, fd, fe);
      check(rv == 1'b1, $sformatf("R9 vector %0d rspValid", i), {63'd0, rv}, 64'd1);
      check(fv == vFwd, $sformatf("R2/R3/R6 vector %0d fwdValid", i), {63'd0, fv}, {63'd0, vFwd});
      if (vFwd)
        check(fd == vD[2:0] && fe == vE, $sformatf("R1 vector %0d fwd target", i),
              {60'd0, fe, fd}, {60'd0, vE, vD[2:0]});
      if (!vWr) begin
        expData = (vRet == 8'hFF) ? '1 : {vRet, 56'd0};
        check(data == expData, $sformatf("R9 vector %0d load data", i), data, expData);
      end
    end

    // R10 reset in mid run clears state (desc 0 notification is 10)
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(rspValid == 1'b0 && fwdValid == 1'b0, "R10 mid reset outputs",
          {62'd0, rspValid, fwdValid}, 64'd0);
    rstN = 1'b1;
    access(1'b0, 4'd0, 1'b0, 12'h800, 2'd3, rv, data, fv, fd, fe);
    check(data == 64'd0, "R10 state cleared", data, 64'd0);
    access(1'b0, 4'd1, 1'b1, 12'h800, 2'd3, rv, data, fv, fd, fe);
    check(data == 64'd0, "R10 escalation cleared", data, 64'd0);

    // R9 response lasts one cycle only
    @(negedge clk);
    check(rspValid == 1'b0, "R9 single-cycle response", {63'd0, rspValid}, 64'd0);

    // R2 forward on descriptor 7 reports its index
    access(1'b1, 4'd7, 1'b1, 12'h008, 2'd3, rv, data, fv, fd, fe);
    check(fv && fd == 3'd7 && fe, "R2 forward target desc 7",
          {60'd0, fv, fe, fd}, {60'd0, 1'b1, 1'b1, 3'd7});

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule